// File: doc/BRIEF.md
# Pattern-Replay Clock Waveform Generator

This block derives a slower clock from a fast input clock by replaying a stored bit pattern, one bit per input cycle. The period of the derived clock is set by an end index: the pattern is read from bit 0 upward and wraps to bit 0 after the bit at the end index. The pattern bits therefore carry both the division ratio and the phase offset. A companion package function builds such a pattern for a power-of-two ratio and a shift of zero to two cycles.

Two further settings are applied at the same time as the pattern. One chooses whether the output register updates on the rising or the falling edge of the input clock. The other either enables replay or bypasses it, so that the input clock passes straight to the output. The whole configuration is taken in only while reset is held. A change on the configuration pins therefore cannot disturb a running waveform.

Top module: `patclk_gen`

## Requirements
- R1: A synchronous active-high reset clears the pattern index to 0 and drives the replay output low. With replay enabled, clk_out stays 0 on every edge that sees reset high.
- R2: The four configuration inputs (pat_cfg, last_idx, replay_en, rise_sel) are captured on each rising edge that sees reset high, and only then. While reset is low, changes on them have no effect on clk_out.
- R3: After reset is released, each selected edge drives pattern bit [index] onto the output register and advances the index by one. Bit 0 is emitted first.
- R4: After the bit at last_idx has been emitted, the next bit emitted is bit 0, so the output repeats every last_idx+1 cycles. last_idx=15 uses all 16 bits, and last_idx=0 repeats bit 0 forever.
- R5: With rise_sel=1 the output register updates on the rising edge of clk_in. With rise_sel=0 it updates on the falling edge, half a cycle later, and emits bit 0 on the first falling edge that sees reset low.
- R6: With replay_en=0 captured, clk_out equals clk_in at all times.
- R7: build_pattern(N,S) sets bit i to 1 exactly when ((i+S) mod N) >= N/2, for N in {2,4,8,16} and S in {0,1,2}. Replayed with last_idx=15, the output has a period of N cycles. Its first rising transition appears in output cycle ((N/2-S) mod N), where output cycle 0 is the one that carries bit 0.
- R8: build_pattern(4,1) returns 16'h6666, which is the divide-by-4 waveform shifted by one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Fast input clock |
| rst | input | 1 | Synchronous active-high reset; configuration is captured while it is high |
| pat_cfg | input | 16 | Waveform pattern, bit 0 replayed first |
| last_idx | input | 4 | Index of the last pattern bit before the wrap to bit 0 |
| replay_en | input | 1 | 1 selects pattern replay, 0 passes clk_in through |
| rise_sel | input | 1 | 1 updates the output on the rising edge, 0 on the falling edge |
| clk_out | output | 1 | Derived clock |

## Verification
Two events can meet on the same edge: the index wrap, and a reset or a configuration change. The bench re-asserts reset in the middle of a running period. It also moves every configuration pin while replay is running. Across all of this, a behavioural model advances its own stream position, and that model is compared with clk_out twice in every cycle. A sweep over every legal ratio, shift and edge then measures the distance between rising output transitions and the position of the first one, and compares both with values derived from the ratio and the shift alone.

// File: rtl/patclk_pkg.sv
package patclk_pkg;

  localparam int unsigned PAT_W = 16;
  localparam int unsigned IDX_W = $clog2(PAT_W);

  // Pattern for a power-of-two division: a half-period of zeros and then
  // a half-period of ones, advanced by `shift` positions.
  function automatic logic [PAT_W-1:0] build_pattern(input int unsigned ratio,
                                                     input int unsigned shift);
    logic [PAT_W-1:0] p;
    p = '0;
    if (ratio != 0) begin
      for (int unsigned i = 0; i < PAT_W; i++) begin
        p[i] = (((i + shift) % ratio) >= (ratio / 2));
      end
    end
    return p;
  endfunction

endpackage

// File: rtl/patclk_cfgreg.sv
module patclk_cfgreg #(
  parameter int unsigned PAT_W = 16,
  parameter int unsigned IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [PAT_W-1:0] pat_i,
  input  logic [IDX_W-1:0] last_i,
  input  logic             replay_i,
  input  logic             rise_i,
  output logic [PAT_W-1:0] pat_o,
  output logic [IDX_W-1:0] last_o,
  output logic             replay_o,
  output logic             rise_o
);

  // Configuration is loaded only while reset is held.
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      pat_o    <= pat_i;
      last_o   <= last_i;
      replay_o <= replay_i;
      rise_o   <= rise_i;
    end
  end

endmodule

// File: rtl/patclk_seq.sv
module patclk_seq #(
  parameter int unsigned PAT_W   = 16,
  parameter int unsigned IDX_W   = 4,
  parameter bit          FALLING = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [PAT_W-1:0] pat_i,
  input  logic [IDX_W-1:0] last_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             bit_o,
  output logic             wrap_o
);

  localparam logic [IDX_W-1:0] IDX_ONE = IDX_W'(1);

  logic [IDX_W-1:0] idx_d;
  logic             bit_d;

  assign wrap_o = (idx_o == last_i);

  always_comb begin
    if (rst_i) begin
      idx_d = '0;
      bit_d = 1'b0;
    end else begin
      bit_d = pat_i[idx_o];
      idx_d = wrap_o ? '0 : idx_o + IDX_ONE;
    end
  end

  generate
    if (FALLING) begin : g_fall
      always_ff @(negedge clk_i) begin
        idx_o <= idx_d;
        bit_o <= bit_d;
      end
    end else begin : g_rise
      always_ff @(posedge clk_i) begin
        idx_o <= idx_d;
        bit_o <= bit_d;
      end
    end
  endgenerate

endmodule

// File: rtl/patclk_omux.sv
module patclk_omux (
  input  logic clk_i,
  input  logic replay_i,
  input  logic rise_i,
  input  logic rise_bit_i,
  input  logic fall_bit_i,
  output logic clk_o
);

  always_comb begin
    if (!replay_i)   clk_o = clk_i;
    else if (rise_i) clk_o = rise_bit_i;
    else             clk_o = fall_bit_i;
  end

endmodule

// File: rtl/patclk_gen.sv
module patclk_gen #(
  parameter int unsigned PAT_W = patclk_pkg::PAT_W,
  parameter int unsigned IDX_W = $clog2(PAT_W)
) (
  input  logic             clk_in,
  input  logic             rst,
  input  logic [PAT_W-1:0] pat_cfg,
  input  logic [IDX_W-1:0] last_idx,
  input  logic             replay_en,
  input  logic             rise_sel,
  output logic             clk_out
);

  localparam int unsigned N_SEQ = 2;

  logic [PAT_W-1:0] cfg_pat;
  logic [IDX_W-1:0] cfg_last;
  logic             cfg_replay;
  logic             cfg_rise;

  logic [IDX_W-1:0] seq_idx  [N_SEQ];
  logic             seq_bit  [N_SEQ];
  logic             seq_wrap [N_SEQ];

  // Named internal events for the checker
  logic [IDX_W-1:0] rise_idx, fall_idx;
  logic             rise_bit, fall_bit;
  logic             rise_wrap, fall_wrap;

  patclk_cfgreg #(.PAT_W(PAT_W), .IDX_W(IDX_W)) u_cfg (
    .clk_i    (clk_in),
    .rst_i    (rst),
    .pat_i    (pat_cfg),
    .last_i   (last_idx),
    .replay_i (replay_en),
    .rise_i   (rise_sel),
    .pat_o    (cfg_pat),
    .last_o   (cfg_last),
    .replay_o (cfg_replay),
    .rise_o   (cfg_rise)
  );

  // Index 0 runs on the rising edge, index 1 on the falling edge.
  for (genvar g = 0; g < N_SEQ; g++) begin : g_seq
    patclk_seq #(.PAT_W(PAT_W), .IDX_W(IDX_W), .FALLING(g != 0)) u_seq (
      .clk_i  (clk_in),
      .rst_i  (rst),
      .pat_i  (cfg_pat),
      .last_i (cfg_last),
      .idx_o  (seq_idx[g]),
      .bit_o  (seq_bit[g]),
      .wrap_o (seq_wrap[g])
    );
  end

  assign rise_idx  = seq_idx[0];
  assign fall_idx  = seq_idx[1];
  assign rise_bit  = seq_bit[0];
  assign fall_bit  = seq_bit[1];
  assign rise_wrap = seq_wrap[0];
  assign fall_wrap = seq_wrap[1];

  patclk_omux u_omux (
    .clk_i      (clk_in),
    .replay_i   (cfg_replay),
    .rise_i     (cfg_rise),
    .rise_bit_i (rise_bit),
    .fall_bit_i (fall_bit),
    .clk_o      (clk_out)
  );

endmodule

// File: rtl/patclk_gen_chk.sv
module patclk_gen_chk #(
  parameter int unsigned PAT_W = 16,
  parameter int unsigned IDX_W = 4
) (
  input logic             clk_in,
  input logic             rst,
  input logic [PAT_W-1:0] cfg_pat,
  input logic [IDX_W-1:0] cfg_last,
  input logic             cfg_replay,
  input logic             cfg_rise,
  input logic [IDX_W-1:0] rise_idx,
  input logic [IDX_W-1:0] fall_idx,
  input logic             rise_bit,
  input logic             fall_bit,
  input logic             rise_wrap,
  input logic             fall_wrap
);

  localparam logic [IDX_W-1:0] IDX_ONE = IDX_W'(1);

  // R1
  rise_reset_clear_chk: assert property (@(posedge clk_in)
    rst |=> (rise_idx == '0 && !rise_bit));

  // R1
  fall_reset_clear_chk: assert property (@(negedge clk_in)
    rst |=> (fall_idx == '0 && !fall_bit));

  // R2
  cfg_hold_chk: assert property (@(posedge clk_in)
    !rst |=> ($stable(cfg_pat) && $stable(cfg_last) && $stable(cfg_replay) && $stable(cfg_rise)));

  // R3
  rise_advance_chk: assert property (@(posedge clk_in) disable iff (rst)
    !rise_wrap |=> rise_idx == $past(rise_idx) + IDX_ONE);

  // R5
  fall_advance_chk: assert property (@(negedge clk_in) disable iff (rst)
    !fall_wrap |=> fall_idx == $past(fall_idx) + IDX_ONE);

  // R4
  rise_wrap_chk: assert property (@(posedge clk_in) disable iff (rst)
    rise_wrap |=> rise_idx == '0);

  // R4
  fall_wrap_chk: assert property (@(negedge clk_in) disable iff (rst)
    fall_wrap |=> fall_idx == '0);

  // R4
  rise_bound_chk: assert property (@(posedge clk_in) disable iff (rst)
    rise_idx <= cfg_last);

endmodule

bind patclk_gen patclk_gen_chk #(.PAT_W(PAT_W), .IDX_W(IDX_W)) u_chk (
  .clk_in     (clk_in),
  .rst        (rst),
  .cfg_pat    (cfg_pat),
  .cfg_last   (cfg_last),
  .cfg_replay (cfg_replay),
  .cfg_rise   (cfg_rise),
  .rise_idx   (rise_idx),
  .fall_idx   (fall_idx),
  .rise_bit   (rise_bit),
  .fall_bit   (fall_bit),
  .rise_wrap  (rise_wrap),
  .fall_wrap  (fall_wrap)
);

// File: tb/patclk_gen_bench.sv
`timescale 1ns/1ps
module patclk_gen_bench;
  import patclk_pkg::*;

  localparam int PW = 16;
  localparam int IW = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          drv_rst  = 1'b1;
  logic [PW-1:0] drv_pat  = 16'h6666;
  logic [IW-1:0] drv_last = 4'd15;
  logic          drv_mode = 1'b1;
  logic          drv_edge = 1'b1;
  logic          clk_out;

  patclk_gen u_patclk_gen (
    .clk_in    (clk),
    .rst       (drv_rst),
    .pat_cfg   (drv_pat),
    .last_idx  (drv_last),
    .replay_en (drv_mode),
    .rise_sel  (drv_edge),
    .clk_out   (clk_out)
  );

  // Behavioural model state
  logic [PW-1:0] m_pat;
  int            m_last;
  logic          m_mode, m_edge;
  int            ridx = 0, fidx = 0, r_emit = 0, f_emit = 0;
  logic          rout = 1'b0, fout = 1'b0;
  bit            r_inrst = 1, f_inrst = 1;
  bit            r2_win = 0;
  int            iter = 0;
  int            vectors = 0, miscompares = 0;
  bit            meas_on = 0;
  logic          prev_out = 1'b0;
  int            rises[$];

  function automatic string pick_tag(bit in_reset, int emitted);
    if (r2_win)          return "R2";
    if (!m_mode)         return "R6";
    if (in_reset)        return "R1";
    if (!m_edge)         return "R5";
    if (emitted == m_last) return "R4";
    return "R3";
  endfunction

  task automatic check_bit(input string tag, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: clk_out=%b expected %b (cycle %0d)", tag, act, exp, iter);
    end
  endtask

  task automatic check_val(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: got %0d expected %0d (cycle %0d)", tag, act, exp, iter);
    end
  endtask

  // Stream built from a queue: half zeros, half ones, rotated S times.
  function automatic logic [PW-1:0] ref_pattern(input int n, input int s);
    int q[$];
    logic [PW-1:0] p;
    for (int k = 0; k < n / 2; k++) q.push_back(0);
    for (int k = 0; k < n / 2; k++) q.push_back(1);
    for (int k = 0; k < s; k++) begin
      int h;
      h = q.pop_front();
      q.push_back(h);
    end
    for (int i = 0; i < PW; i++) p[i] = q[i % n][0];
    return p;
  endfunction

  task automatic step(input logic r, input logic [PW-1:0] p, input logic [IW-1:0] l,
                      input logic md, input logic ed);
    logic exp;
    @(posedge clk);
    // rising edge saw the values driven in the previous cycle
    if (drv_rst) begin
      m_pat = drv_pat; m_last = int'(drv_last); m_mode = drv_mode; m_edge = drv_edge;
      ridx = 0; rout = 1'b0; r_inrst = 1;
    end else begin
      rout = m_pat[ridx]; r_emit = ridx; r_inrst = 0;
      ridx = (ridx == m_last) ? 0 : ridx + 1;
    end
    #1;
    drv_rst = r; drv_pat = p; drv_last = l; drv_mode = md; drv_edge = ed;
    #0.5;
    exp = !m_mode ? 1'b1 : (m_edge ? rout : fout);
    check_bit(m_edge ? pick_tag(r_inrst, r_emit) : pick_tag(f_inrst, f_emit), clk_out, exp);
    #1;
    // falling edge sees the values driven in this cycle
    if (drv_rst) begin
      fidx = 0; fout = 1'b0; f_inrst = 1;
    end else begin
      fout = m_pat[fidx]; f_emit = fidx; f_inrst = 0;
      fidx = (fidx == m_last) ? 0 : fidx + 1;
    end
    #1.5;
    exp = !m_mode ? 1'b0 : (m_edge ? rout : fout);
    check_bit(m_edge ? pick_tag(r_inrst, r_emit) : pick_tag(f_inrst, f_emit), clk_out, exp);
    if (meas_on) begin
      if (clk_out === 1'b1 && prev_out === 1'b0) rises.push_back(iter);
      prev_out = clk_out;
    end
    iter++;
  endtask

  task automatic sweep(input int n, input int s, input logic ed);
    logic [PW-1:0] p;
    int base, rel, want;
    p = ref_pattern(n, s);
    check_val("R7", int'(build_pattern(n, s)), int'(p));
    repeat (3) step(1'b1, p, 4'd15, 1'b1, ed);
    base = iter;
    meas_on = 1; prev_out = 1'b0; rises.delete();
    repeat (3 * n + 8) step(1'b0, p, 4'd15, 1'b1, ed);
    meas_on = 0;
    want = (((n / 2) - s) % n + n) % n;
    check_val("R7", (rises.size() >= 2) ? 1 : 0, 1);
    if (rises.size() >= 2) begin
      rel = rises[0] - base - (ed ? 1 : 0);
      check_val("R7", rel, want);
      check_val("R7", rises[1] - rises[0], n);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: run did not end (got timeout, expected completion)");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin : main
    // R8: divide-by-4, shift one
    check_val("R8", int'(build_pattern(4, 1)), 16'h6666);
    // R1: reset state
    repeat (4) step(1'b1, 16'h6666, 4'd15, 1'b1, 1'b1);
    // R3: replay of the full pattern on the rising edge
    repeat (40) step(1'b0, 16'h6666, 4'd15, 1'b1, 1'b1);
    // R2: move every configuration pin while running
    r2_win = 1;
    repeat (20) step(1'b0, 16'h0F0F, 4'd3, 1'b0, 1'b0);
    r2_win = 0;
    // R1: reset in the middle of a period, then resume
    repeat (2) step(1'b1, 16'h6666, 4'd15, 1'b1, 1'b1);
    repeat (20) step(1'b0, 16'h6666, 4'd15, 1'b1, 1'b1);
    // R4: short period of five bits
    repeat (3) step(1'b1, 16'h0016, 4'd4, 1'b1, 1'b1);
    repeat (30) step(1'b0, 16'h0016, 4'd4, 1'b1, 1'b1);
    // R5: same pattern on the falling edge
    repeat (3) step(1'b1, 16'h0016, 4'd4, 1'b1, 1'b0);
    repeat (30) step(1'b0, 16'h0016, 4'd4, 1'b1, 1'b0);
    // R4: end index 0 repeats bit 0
    repeat (3) step(1'b1, 16'h0001, 4'd0, 1'b1, 1'b1);
    repeat (10) step(1'b0, 16'h0001, 4'd0, 1'b1, 1'b1);
    // R6: pass-through
    repeat (3) step(1'b1, 16'h6666, 4'd15, 1'b0, 1'b1);
    repeat (12) step(1'b0, 16'h6666, 4'd15, 1'b0, 1'b1);
    // R7: every legal ratio, shift and edge
    for (int n = 2; n <= 16; n = n * 2) begin
      for (int s = 0; s <= 2; s++) begin
        sweep(n, s, 1'b1);
        sweep(n, s, 1'b0);
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule